// File: doc/BRIEF.md
# Center-Aligned Space Vector PWM Sequencer

This block turns a sector number and two active-vector dwell times into the three ideal phase switching states of a two-level, three-phase inverter. Each PWM cycle is two half-periods. The first half runs zero vector V0, then the two active vectors of the sector, then zero vector V7. The second half runs the same states in reverse order, so the pattern is symmetric about the centre of the cycle. The leftover zero-vector time is split between the V0 and V7 intervals. If the requested dwell times do not fit in a half-period, they are shrunk in proportion.

A one-tick sync pulse marks the start of every cycle. A one-tick marker flags the first tick of each active-vector interval, and two tag bits say which half of the cycle it falls in and which of the two vectors it belongs to. Downstream current-sampling logic can place its sample instants from these markers. Sector, dwell times and period are captured only at the cycle boundary. Dead time and gate drive belong to later stages.

Top module: `svpwm_seq`

## Requirements
- R1: While rst_ni is low, phase_o is 000 and sync_o, act_start_o, act_second_o and act_sel_o are 0. The first cycle begins on the first rising edge after reset is released.
- R2: phase_o is {U,V,W} with U in bit 2 and 1 meaning the upper switch is on. The codes are V0=000, V1=100, V2=110, V3=010, V4=011, V5=001, V6=101 and V7=111. In sector 1 the first half-period applies V0, then V1 for ta ticks, then V2 for tb ticks, then V7.
- R3: For an odd sector n, the first active vector (A, dwell ta) is Vn and the second (B, dwell tb) is Vn+1. For an even sector n, A is V(n mod 6)+1 and B is Vn. With this order, each step from a zero vector or between A and B changes one phase.
- R4: The second half-period applies V7, B, A, V0 with the same dwell times as the first half. The phase on the first tick of the second half equals the phase on the last tick of the first half.
- R5: The half-period is h = floor(period_i/2), raised to 1 when it would be 0, and a cycle lasts 2h ticks. The zero time T0 = h - ta - tb is split so that V0 gets floor(T0/2) ticks and V7 gets the rest, in each half.
- R6: sync_o is high only on the first tick of each cycle.
- R7: When ta+tb > h, the dwell times used are ta' = floor(ta*h/(ta+tb)) and tb' = h - ta', so T0 = 0.
- R8: period_i, sector_i, ta_i and tb_i are sampled only on the edge that starts a cycle. Changes during a cycle do not affect that cycle.
- R9: act_start_o pulses for one tick on the first tick of every non-empty active interval. act_second_o is 0 in the first half and 1 in the second. act_sel_o is 0 for vector A and 1 for vector B. Both tag bits are 0 when no marker is issued.
- R10: An active interval with zero dwell is omitted and gets no marker. With ta=tb=0 the cycle holds only V0 and V7.
- R11: A sector_i value of 0 or 7 is treated as ta=tb=0: the cycle holds only V0 and V7 and has no markers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one tick per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| period_i | input | CNT_W | Requested PWM period in ticks |
| sector_i | input | 3 | Sector number, 1 to 6 |
| ta_i | input | CNT_W | Dwell of the first active vector per half-period |
| tb_i | input | CNT_W | Dwell of the second active vector per half-period |
| phase_o | output | 3 | Phase states {U,V,W} |
| sync_o | output | 1 | First tick of each cycle |
| act_start_o | output | 1 | First tick of an active interval |
| act_second_o | output | 1 | Marker lies in the second half-period |
| act_sel_o | output | 1 | Marker belongs to vector B (1) or A (0) |

## Verification
The bench steps through all six sectors. A design that paired or ordered the active vectors wrongly would show a two-phase jump or a wrong code in the even sectors. An odd zero time checks the V0/V7 split, where a swapped rounding shifts every edge by one tick. Oversubscribed dwell times check the proportional shrink, which an unclamped design would turn into a long, wrapped cycle. Zero dwells, invalid sectors and one-tick half-periods expose markers issued for empty intervals and a missing or doubled second-half marker at the centre. Inputs are also scrambled mid-cycle, which a design that sampled continuously would show as a glitched pattern.

// File: rtl/svpwm_pkg.sv
package svpwm_pkg;

  localparam int unsigned PH_W  = 3;
  localparam int unsigned SEC_W = 3;

  typedef logic [PH_W-1:0]  phase_t;
  typedef logic [SEC_W-1:0] sector_t;

  typedef enum logic [1:0] {
    SEG_Z0,
    SEG_A,
    SEG_B,
    SEG_Z7
  } seg_e;

  // inverter state number -> {U,V,W}
  function automatic phase_t vec_code(input logic [2:0] k);
    phase_t c;
    case (k)
      3'd0:    c = 3'b000;
      3'd1:    c = 3'b100;
      3'd2:    c = 3'b110;
      3'd3:    c = 3'b010;
      3'd4:    c = 3'b011;
      3'd5:    c = 3'b001;
      3'd6:    c = 3'b101;
      default: c = 3'b111;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/svpwm_sector_map.sv
module svpwm_sector_map
  import svpwm_pkg::*;
(
  input  sector_t sector_i,
  output phase_t  code_a_o,
  output phase_t  code_b_o,
  output logic    valid_o
);

  logic [2:0] idx_a, idx_b;

  always_comb begin
    valid_o = (sector_i >= 3'd1) && (sector_i <= 3'd6);
    idx_a   = 3'd0;
    idx_b   = 3'd0;
    if (valid_o) begin
      if (sector_i[0]) begin
        // odd sector: lower vector has one upper switch on
        idx_a = sector_i;
        idx_b = 3'(sector_i + 3'd1);
      end else begin
        idx_a = (sector_i == 3'd6) ? 3'd1 : 3'(sector_i + 3'd1);
        idx_b = sector_i;
      end
    end
    code_a_o = vec_code(idx_a);
    code_b_o = vec_code(idx_b);
  end

endmodule

// File: rtl/svpwm_time_split.sv
module svpwm_time_split #(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] ta_i,
  input  logic [CNT_W-1:0] tb_i,
  input  logic             valid_i,
  output logic [CNT_W-1:0] half_o,
  output logic [CNT_W-1:0] ta_o,
  output logic [CNT_W-1:0] tb_o,
  output logic [CNT_W-1:0] t0a_o
);

  localparam int unsigned SUM_W  = CNT_W + 1;
  localparam int unsigned PROD_W = 2 * CNT_W;

  logic [CNT_W-1:0]  half_raw, ta_e, tb_e, t0;
  logic [SUM_W-1:0]  sum;
  logic [PROD_W-1:0] prod;

  always_comb begin
    half_raw = period_i >> 1;
    half_o   = (half_raw == '0) ? CNT_W'(1) : half_raw;
    ta_e     = valid_i ? ta_i : '0;
    tb_e     = valid_i ? tb_i : '0;
    sum      = SUM_W'(ta_e) + SUM_W'(tb_e);
    prod     = PROD_W'(ta_e) * PROD_W'(half_o);
    if (sum > SUM_W'(half_o)) begin
      // oversubscribed: shrink both, remainder to B
      ta_o = CNT_W'(prod / PROD_W'(sum));
      tb_o = half_o - ta_o;
    end else begin
      ta_o = ta_e;
      tb_o = tb_e;
    end
    t0    = half_o - ta_o - tb_o;
    t0a_o = t0 >> 1;
  end

endmodule

// File: rtl/svpwm_seg_decode.sv
module svpwm_seg_decode
  import svpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] half_i,
  input  logic [CNT_W-1:0] t0a_i,
  input  logic [CNT_W-1:0] ta_i,
  input  logic [CNT_W-1:0] tb_i,
  input  phase_t           code_a_i,
  input  phase_t           code_b_i,
  output phase_t           phase_o,
  output logic             sync_o,
  output logic             start_o,
  output logic             second_o,
  output logic             sel_o
);

  logic [CNT_W-1:0] two_h, pos, b1, b2, b3;
  logic             in_second, mk_a, mk_b;
  seg_e             seg;
  phase_t           ph;

  always_comb begin
    two_h     = half_i << 1;
    in_second = (cnt_i >= half_i);
    // second half walks the first-half boundaries backwards
    pos       = in_second ? (two_h - CNT_W'(1) - cnt_i) : cnt_i;
    b1        = t0a_i;
    b2        = b1 + ta_i;
    b3        = b2 + tb_i;

    if (pos < b1)      seg = SEG_Z0;
    else if (pos < b2) seg = SEG_A;
    else if (pos < b3) seg = SEG_B;
    else               seg = SEG_Z7;

    case (seg)
      SEG_Z0:  ph = 3'b000;
      SEG_A:   ph = code_a_i;
      SEG_B:   ph = code_b_i;
      default: ph = 3'b111;
    endcase

    if (!in_second) begin
      mk_a = (ta_i != '0) && (pos == b1);
      mk_b = (tb_i != '0) && (pos == b2);
    end else begin
      mk_a = (ta_i != '0) && (pos == b2 - CNT_W'(1));
      mk_b = (tb_i != '0) && (pos == b3 - CNT_W'(1));
    end

    phase_o  = en_i ? ph : 3'b000;
    sync_o   = en_i && (cnt_i == '0);
    start_o  = en_i && (mk_a || mk_b);
    second_o = start_o && in_second;
    sel_o    = start_o && mk_b;
  end

  a_r4_center_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_i == half_i) |-> (phase_o == $past(phase_o)));

  a_r6_sync_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !sync_o);

  a_r9_marker_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (phase_o != 3'b000 && phase_o != 3'b111));

  a_r9_marker_sel_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && !sel_o) |-> (phase_o == code_a_i));

endmodule

// File: rtl/svpwm_seq.sv
module svpwm_seq
  import svpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic [2:0]       sector_i,
  input  logic [CNT_W-1:0] ta_i,
  input  logic [CNT_W-1:0] tb_i,
  output logic [2:0]       phase_o,
  output logic             sync_o,
  output logic             act_start_o,
  output logic             act_second_o,
  output logic             act_sel_o
);

  logic             started;
  logic [CNT_W-1:0] cnt, last, half_q, ta_q, tb_q, t0a_q;
  phase_t           code_a_q, code_b_q;

  phase_t           code_a_n, code_b_n;
  logic             sec_valid;
  logic [CNT_W-1:0] half_n, ta_n, tb_n, t0a_n;
  logic             load;

  svpwm_sector_map u_map (
    .sector_i (sector_i),
    .code_a_o (code_a_n),
    .code_b_o (code_b_n),
    .valid_o  (sec_valid)
  );

  svpwm_time_split #(.CNT_W(CNT_W)) u_split (
    .period_i (period_i),
    .ta_i     (ta_i),
    .tb_i     (tb_i),
    .valid_i  (sec_valid),
    .half_o   (half_n),
    .ta_o     (ta_n),
    .tb_o     (tb_n),
    .t0a_o    (t0a_n)
  );

  assign last = (half_q << 1) - CNT_W'(1);
  assign load = !started || (cnt == last);

  // settings are captured only at the cycle boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started  <= 1'b0;
      cnt      <= '0;
      half_q   <= CNT_W'(1);
      ta_q     <= '0;
      tb_q     <= '0;
      t0a_q    <= '0;
      code_a_q <= 3'b000;
      code_b_q <= 3'b000;
    end else if (load) begin
      started  <= 1'b1;
      cnt      <= '0;
      half_q   <= half_n;
      ta_q     <= ta_n;
      tb_q     <= tb_n;
      t0a_q    <= t0a_n;
      code_a_q <= code_a_n;
      code_b_q <= code_b_n;
    end else begin
      cnt      <= cnt + CNT_W'(1);
    end
  end

  svpwm_seg_decode #(.CNT_W(CNT_W)) u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (started),
    .cnt_i    (cnt),
    .half_i   (half_q),
    .t0a_i    (t0a_q),
    .ta_i     (ta_q),
    .tb_i     (tb_q),
    .code_a_i (code_a_q),
    .code_b_i (code_b_q),
    .phase_o  (phase_o),
    .sync_o   (sync_o),
    .start_o  (act_start_o),
    .second_o (act_second_o),
    .sel_o    (act_sel_o)
  );

  a_r5_cnt_in_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started |-> (cnt < (half_q << 1)));

  a_r7_dwell_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started |-> ((CNT_W+1)'(ta_q) + (CNT_W+1)'(tb_q) <= (CNT_W+1)'(half_q)));

endmodule

// File: tb/svpwm_seq_tb.sv
module svpwm_seq_tb;

  localparam int unsigned CNT_W = 16;

  typedef struct {
    logic [2:0] ph;
    logic       sy;
    logic       st;
    logic       sc;
    logic       sl;
    string      tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [CNT_W-1:0] period_i = '0;
  logic [2:0]       sector_i = '0;
  logic [CNT_W-1:0] ta_i = '0;
  logic [CNT_W-1:0] tb_i = '0;
  logic [2:0]       phase_o;
  logic             sync_o, act_start_o, act_second_o, act_sel_o;

  exp_t q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  logic mon_en  = 1'b0;

  always #2 clk = ~clk;

  svpwm_seq #(.CNT_W(CNT_W)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .period_i     (period_i),
    .sector_i     (sector_i),
    .ta_i         (ta_i),
    .tb_i         (tb_i),
    .phase_o      (phase_o),
    .sync_o       (sync_o),
    .act_start_o  (act_start_o),
    .act_second_o (act_second_o),
    .act_sel_o    (act_sel_o)
  );

  function automatic logic [2:0] vcode(input int k);
    case (k)
      0: return 3'b000;
      1: return 3'b100;
      2: return 3'b110;
      3: return 3'b010;
      4: return 3'b011;
      5: return 3'b001;
      6: return 3'b101;
      default: return 3'b111;
    endcase
  endfunction

  task automatic push_seg(input logic [2:0] code, input int len, input bit mark,
                          input bit sec, input bit sel, input string tag,
                          inout bit first);
    for (int i = 0; i < len; i++) begin
      exp_t e;
      e.ph  = code;
      e.sy  = first;
      e.st  = mark && (i == 0);
      e.sc  = e.st && sec;
      e.sl  = e.st && sel;
      e.tag = tag;
      q.push_back(e);
      first = 1'b0;
    end
  endtask

  task automatic push_period(input int p, input int s, input int ta, input int tb,
                             input string tag, output int len);
    int h, a, b, t0, z0, z7, va, vb;
    bit valid, first;
    longint a2;
    h = p / 2;
    if (h == 0) h = 1;
    valid = (s >= 1) && (s <= 6);
    a = valid ? ta : 0;
    b = valid ? tb : 0;
    if (a + b > h) begin
      a2 = (longint'(a) * longint'(h)) / longint'(a + b);
      a  = int'(a2);
      b  = h - a;
    end
    t0 = h - a - b;
    z0 = t0 / 2;
    z7 = t0 - z0;
    if (s % 2 == 1) begin va = s; vb = s + 1; end
    else begin va = (s == 6) ? 1 : s + 1; vb = s; end
    first = 1'b1;
    push_seg(3'b000,    z0, 1'b0, 1'b0, 1'b0, tag, first);
    push_seg(vcode(va), a,  1'b1, 1'b0, 1'b0, tag, first);
    push_seg(vcode(vb), b,  1'b1, 1'b0, 1'b1, tag, first);
    push_seg(3'b111,    z7, 1'b0, 1'b0, 1'b0, tag, first);
    push_seg(3'b111,    z7, 1'b0, 1'b1, 1'b0, tag, first);
    push_seg(vcode(vb), b,  1'b1, 1'b1, 1'b1, tag, first);
    push_seg(vcode(va), a,  1'b1, 1'b1, 1'b0, tag, first);
    push_seg(3'b000,    z0, 1'b0, 1'b1, 1'b0, tag, first);
    len = 2 * h;
  endtask

  task automatic set_inputs(input int p, input int s, input int ta, input int tb);
    period_i = CNT_W'(p);
    sector_i = 3'(s);
    ta_i     = CNT_W'(ta);
    tb_i     = CNT_W'(tb);
  endtask

  // driver: queue the next cycle, wait until it is latched, optionally scramble inputs
  task automatic run_period(input int p, input int s, input int ta, input int tb,
                            input string tag, input bit noise);
    int len;
    set_inputs(p, s, ta, tb);
    push_period(p, s, ta, tb, tag, len);
    while (q.size() > len) @(posedge clk);
    #1;
    if (noise) begin
      set_inputs(p + 10, 3, 1, 1);
      @(posedge clk); #1;
      set_inputs(2, 0, 9, 9);
      @(posedge clk); #1;
      set_inputs(p + 2, 5, 2, 7);
      @(posedge clk); #1;
    end
  endtask

  // monitor: pops one expected item per tick
  always @(negedge clk) begin
    if (mon_en && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_tests++;
      if (phase_o !== e.ph || sync_o !== e.sy || act_start_o !== e.st ||
          act_second_o !== e.sc || act_sel_o !== e.sl) begin
        n_fail++;
        $display("FAIL %s: phase/sync/start/second/sel actual=%b %b %b %b %b expected=%b %b %b %b %b",
                 e.tag, phase_o, sync_o, act_start_o, act_second_o, act_sel_o,
                 e.ph, e.sy, e.st, e.sc, e.sl);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int len0;
    set_inputs(40, 1, 6, 4);
    push_period(40, 1, 6, 4, "R2", len0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    n_tests++;
    if (phase_o !== 3'b000 || sync_o !== 1'b0 || act_start_o !== 1'b0 ||
        act_second_o !== 1'b0 || act_sel_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: reset outputs actual=%b %b %b %b %b expected=000 0 0 0 0",
               phase_o, sync_o, act_start_o, act_second_o, act_sel_o);
    end
    @(posedge clk); #1;
    rst_ni = 1'b1;
    @(posedge clk); #1;
    mon_en = 1'b1;

    run_period(30, 2, 5, 3, "R3", 1'b0);
    run_period(30, 3, 5, 3, "R3", 1'b0);
    run_period(30, 4, 5, 3, "R3", 1'b0);
    run_period(30, 5, 5, 3, "R3", 1'b0);
    run_period(30, 6, 5, 3, "R3", 1'b0);
    run_period(23, 1, 4, 2, "R5", 1'b0);
    run_period(20, 1, 9, 6, "R7", 1'b0);
    run_period(20, 3, 0, 5, "R10", 1'b0);
    run_period(20, 5, 0, 0, "R10", 1'b0);
    run_period(20, 2, 4, 0, "R10", 1'b0);
    run_period(20, 0, 3, 3, "R11", 1'b0);
    run_period(20, 7, 3, 3, "R11", 1'b0);
    run_period(24, 4, 6, 4, "R8", 1'b1);
    run_period(20, 4, 6, 4, "R4", 1'b0);
    run_period(3, 1, 1, 0, "R9", 1'b0);
    run_period(0, 6, 0, 0, "R6", 1'b0);
    run_period(40, 6, 12, 7, "R9", 1'b0);

    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule